// File: doc/BRIEF.md
# Configuration Port Key Lock with Banked Device Settings

This block is the configuration front end of a legacy peripheral controller as a host sees it over a byte-wide I/O bus. Two consecutive I/O addresses form a pointer/value pair. The block ignores every byte written to the value address until the host unlocks configuration. To unlock, the host writes the unlock key byte to the pointer address twice in a row. While configuration is unlocked, the host writes a register number to the pointer address and then reads or writes that register through the value address. A distinct lock key written to the pointer address closes configuration again.

The register file is banked by logical device. One register picks the logical device. The other registers hold the activation bit and the 16-bit I/O base of whichever device is selected. The block drives the activation bit and base of every device on its outputs, so downstream functions can decode their own address windows. Firmware brings a device up in a fixed order: select it, deactivate it, program the base, then activate it.

Top module: `sio_cfg_unlock`

## Requirements
- R1: After reset every device is inactive with base 0x0000, configuration is locked, and value-port reads return 0xFF.
- R2: Configuration unlocks only after two consecutive pointer-port writes of 0xA5. One 0xA5 alone leaves it locked.
- R3: After a single 0xA5, any pointer-port write of another byte, or any value-port read or write, returns the sequence to the fully locked start. Pointer-port reads and accesses to other addresses do not affect it.
- R4: While unlocked, a pointer-port write of 0xAA locks configuration.
- R5: While locked, value-port writes change nothing, and reads of either port return 0xFF.
- R6: While unlocked, a pointer-port read returns the last register number written there. That number is 0x00 after reset.
- R7: Register 0x07 holds the selected device number (8 bits) and reads back as written.
- R8: Register 0x30 bit 0 is the activation bit of the selected device and reads as {7'b0, bit}. A device's enable output changes only on the clock edge of a value-port write while unlocked.
- R9: Register 0x60 holds base bits 15:8 and register 0x61 holds base bits 7:0 of the selected device. Device d drives dev_base[16*d+15:16*d].
- R10: When the selected device number is NUM_DEV or above, writes to registers 0x30/0x60/0x61 are ignored and those registers read 0x00. Unlisted register numbers also read 0x00 and ignore writes.
- R11: With alt_sel=0 the pointer/value pair is 0x004E/0x004F, and with alt_sel=1 it is 0x002E/0x002F. Accesses to any other address have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| io_wr | input | 1 | Byte write strobe, one cycle per access |
| io_rd | input | 1 | Byte read strobe, one cycle per access |
| io_addr | input | ADDR_W | I/O address of the access |
| io_wdata | input | 8 | Write byte |
| io_rdata | output | 8 | Read byte, valid in the cycle io_rd is high |
| alt_sel | input | 1 | Port-pair strap: 0 selects 0x4E/0x4F, 1 selects 0x2E/0x2F |
| dev_en | output | NUM_DEV | Activation bit per logical device |
| dev_base | output | 16*NUM_DEV | I/O base per logical device, device 0 in the low bits |

## Verification
The hardest state to reach is the half-unlocked state after one key byte, because a single stray access leaves it silently. From the ports, the only evidence is whether a later single key byte unlocks or not. The stimulus therefore interrupts the key pair in each possible way: a wrong pointer byte, a value read, a value write, a pointer read, and a write to a foreign address. After each, it probes the mode with pointer reads. A second hard case is an out-of-range device number. The bench selects one, writes all three device registers, and shows through the per-cycle output comparison that no device changed.

// File: rtl/sio_pkg.sv
package sio_pkg;
   typedef enum logic [1:0] {
      KS_LOCKED = 2'd0,
      KS_HALF   = 2'd1,
      KS_OPEN   = 2'd2
   } key_state_e;

   localparam int unsigned BASE_W = 16;

   localparam logic [7:0] REG_DEVSEL  = 8'h07;
   localparam logic [7:0] REG_ACTIVE  = 8'h30;
   localparam logic [7:0] REG_BASE_HI = 8'h60;
   localparam logic [7:0] REG_BASE_LO = 8'h61;
   localparam logic [7:0] NO_DRIVE    = 8'hFF;
endpackage

// File: rtl/sio_port_decode.sv
module sio_port_decode #(
   parameter int unsigned       ADDR_W    = 16,
   parameter logic [ADDR_W-1:0] PRI_INDEX = 'h4E,
   parameter logic [ADDR_W-1:0] ALT_INDEX = 'h2E
) (
   input  logic              io_wr,
   input  logic              io_rd,
   input  logic [ADDR_W-1:0] io_addr,
   input  logic              alt_sel,
   output logic              ptr_wr,
   output logic              ptr_rd,
   output logic              val_wr,
   output logic              val_rd
);
   logic [ADDR_W-1:0] ptr_addr;
   logic [ADDR_W-1:0] val_addr;
   logic              rd_only;

   assign ptr_addr = alt_sel ? ALT_INDEX : PRI_INDEX;
   assign val_addr = ptr_addr + ADDR_W'(1);
   assign rd_only  = io_rd & ~io_wr;

   assign ptr_wr = io_wr   & (io_addr == ptr_addr);
   assign val_wr = io_wr   & (io_addr == val_addr);
   assign ptr_rd = rd_only & (io_addr == ptr_addr);
   assign val_rd = rd_only & (io_addr == val_addr);
endmodule

// File: rtl/sio_key_fsm.sv
module sio_key_fsm
   import sio_pkg::*;
#(
   parameter logic [7:0] ENTRY_KEY = 8'hA5,
   parameter logic [7:0] EXIT_KEY  = 8'hAA
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       ptr_wr,
   input  logic       val_wr,
   input  logic       val_rd,
   input  logic [7:0] wdata,
   output key_state_e key_st,
   output logic       cfg_open,
   output logic [7:0] reg_ptr
);
   key_state_e nxt_st;
   logic       ptr_load;

   always_comb begin
      nxt_st   = key_st;
      ptr_load = 1'b0;
      unique case (key_st)
         KS_LOCKED: begin
            if (ptr_wr && wdata == ENTRY_KEY) nxt_st = KS_HALF;
         end
         KS_HALF: begin
            if (ptr_wr)               nxt_st = (wdata == ENTRY_KEY) ? KS_OPEN : KS_LOCKED;
            else if (val_wr || val_rd) nxt_st = KS_LOCKED;
         end
         KS_OPEN: begin
            if (ptr_wr) begin
               if (wdata == EXIT_KEY) nxt_st = KS_LOCKED;
               else                   ptr_load = 1'b1;
            end
         end
         default: nxt_st = KS_LOCKED;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         key_st  <= KS_LOCKED;
         reg_ptr <= 8'h00;
      end else begin
         key_st <= nxt_st;
         if (ptr_load) reg_ptr <= wdata;
      end
   end

   assign cfg_open = (key_st == KS_OPEN);
endmodule

// File: rtl/sio_dev_bank.sv
module sio_dev_bank
   import sio_pkg::*;
#(
   parameter int unsigned NUM_DEV = 4
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      wr_en,
   input  logic [7:0]                reg_ptr,
   input  logic [7:0]                wdata,
   output logic [7:0]                rd_val,
   output logic [NUM_DEV-1:0]        dev_en,
   output logic [NUM_DEV*BASE_W-1:0] dev_base
);
   localparam logic [8:0] DEV_LIMIT = 9'(NUM_DEV);

   logic              [7:0] devsel;
   logic                    sel_ok;
   logic                    en_rd;
   logic [BASE_W-1:0]       base_rd;

   assign sel_ok = ({1'b0, devsel} < DEV_LIMIT);

   always_ff @(posedge clk) begin
      if (!rst_n)                              devsel <= 8'h00;
      else if (wr_en && reg_ptr == REG_DEVSEL) devsel <= wdata;
   end

   for (genvar d = 0; d < NUM_DEV; d++) begin : g_dev
      logic              hit;
      logic              en_q;
      logic [BASE_W-1:0] base_q;

      assign hit = wr_en & sel_ok & (devsel == 8'(d));

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            en_q   <= 1'b0;
            base_q <= '0;
         end else if (hit) begin
            case (reg_ptr)
               REG_ACTIVE:  en_q         <= wdata[0];
               REG_BASE_HI: base_q[15:8] <= wdata;
               REG_BASE_LO: base_q[7:0]  <= wdata;
               default:     ;
            endcase
         end
      end

      assign dev_en[d]                   = en_q;
      assign dev_base[d*BASE_W +: BASE_W] = base_q;
   end

   always_comb begin
      en_rd   = 1'b0;
      base_rd = '0;
      for (int d = 0; d < NUM_DEV; d++) begin
         if (sel_ok && devsel == 8'(d)) begin
            en_rd   = dev_en[d];
            base_rd = dev_base[d*BASE_W +: BASE_W];
         end
      end
   end

   always_comb begin
      case (reg_ptr)
         REG_DEVSEL:  rd_val = devsel;
         REG_ACTIVE:  rd_val = {7'b0, en_rd};
         REG_BASE_HI: rd_val = base_rd[15:8];
         REG_BASE_LO: rd_val = base_rd[7:0];
         default:     rd_val = 8'h00;
      endcase
   end
endmodule

// File: rtl/sio_cfg_unlock.sv
module sio_cfg_unlock
   import sio_pkg::*;
#(
   parameter int unsigned       NUM_DEV   = 4,
   parameter int unsigned       ADDR_W    = 16,
   parameter logic [ADDR_W-1:0] PRI_INDEX = 'h4E,
   parameter logic [ADDR_W-1:0] ALT_INDEX = 'h2E,
   parameter logic [7:0]        ENTRY_KEY = 8'hA5,
   parameter logic [7:0]        EXIT_KEY  = 8'hAA
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      io_wr,
   input  logic                      io_rd,
   input  logic [ADDR_W-1:0]         io_addr,
   input  logic [7:0]                io_wdata,
   output logic [7:0]                io_rdata,
   input  logic                      alt_sel,
   output logic [NUM_DEV-1:0]        dev_en,
   output logic [NUM_DEV*BASE_W-1:0] dev_base
);
   if (NUM_DEV < 1 || NUM_DEV > 255) begin : g_bad_ndev
      $error("NUM_DEV must lie in 1..255");
   end
   if (ADDR_W < 8) begin : g_bad_aw
      $error("ADDR_W must be at least 8");
   end
   if (ENTRY_KEY == EXIT_KEY) begin : g_bad_key
      $error("entry and exit keys must differ");
   end

   logic       ptr_wr, ptr_rd, val_wr, val_rd;
   key_state_e key_st;
   logic       cfg_open;
   logic [7:0] reg_ptr;
   logic [7:0] bank_rd;

   sio_port_decode #(
      .ADDR_W(ADDR_W), .PRI_INDEX(PRI_INDEX), .ALT_INDEX(ALT_INDEX)
   ) u_dec (
      .io_wr(io_wr), .io_rd(io_rd), .io_addr(io_addr), .alt_sel(alt_sel),
      .ptr_wr(ptr_wr), .ptr_rd(ptr_rd), .val_wr(val_wr), .val_rd(val_rd)
   );

   sio_key_fsm #(
      .ENTRY_KEY(ENTRY_KEY), .EXIT_KEY(EXIT_KEY)
   ) u_fsm (
      .clk(clk), .rst_n(rst_n), .ptr_wr(ptr_wr), .val_wr(val_wr),
      .val_rd(val_rd), .wdata(io_wdata), .key_st(key_st),
      .cfg_open(cfg_open), .reg_ptr(reg_ptr)
   );

   sio_dev_bank #(
      .NUM_DEV(NUM_DEV)
   ) u_bank (
      .clk(clk), .rst_n(rst_n), .wr_en(val_wr & cfg_open),
      .reg_ptr(reg_ptr), .wdata(io_wdata), .rd_val(bank_rd),
      .dev_en(dev_en), .dev_base(dev_base)
   );

   always_comb begin
      if (!cfg_open)   io_rdata = NO_DRIVE;
      else if (ptr_rd) io_rdata = reg_ptr;
      else if (val_rd) io_rdata = bank_rd;
      else             io_rdata = NO_DRIVE;
   end
endmodule

// File: rtl/sio_cfg_unlock_chk.sv
module sio_cfg_unlock_chk
   import sio_pkg::*;
#(
   parameter int unsigned       NUM_DEV   = 4,
   parameter int unsigned       ADDR_W    = 16,
   parameter logic [ADDR_W-1:0] PRI_INDEX = 'h4E,
   parameter logic [ADDR_W-1:0] ALT_INDEX = 'h2E,
   parameter logic [7:0]        ENTRY_KEY = 8'hA5,
   parameter logic [7:0]        EXIT_KEY  = 8'hAA
) (
   input logic                      clk,
   input logic                      rst_n,
   input logic                      io_wr,
   input logic                      io_rd,
   input logic [ADDR_W-1:0]         io_addr,
   input logic [7:0]                io_wdata,
   input logic [7:0]                io_rdata,
   input logic                      alt_sel,
   input logic [1:0]                key_st,
   input logic [NUM_DEV-1:0]        dev_en,
   input logic [NUM_DEV*BASE_W-1:0] dev_base
);
   logic [ADDR_W-1:0] a_ptr, a_val;
   logic              is_open;
   assign a_ptr   = alt_sel ? ALT_INDEX : PRI_INDEX;
   assign a_val   = a_ptr + ADDR_W'(1);
   assign is_open = (key_st == KS_OPEN);

   p_locked_reads_ff_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (io_rd && !io_wr && !is_open) |-> (io_rdata == 8'hFF));

   p_open_needs_key_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (!is_open && !(io_wr && io_addr == a_ptr && io_wdata == ENTRY_KEY)) |=> !is_open);

   p_half_abort_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (key_st == KS_HALF && !io_wr && io_rd && io_addr == a_val) |=> (key_st == KS_LOCKED));

   p_exit_key_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (is_open && io_wr && io_addr == a_ptr && io_wdata == EXIT_KEY) |=> (key_st == KS_LOCKED));

   p_outputs_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !(io_wr && io_addr == a_val && is_open) |=> ($stable(dev_en) && $stable(dev_base)));
endmodule

bind sio_cfg_unlock sio_cfg_unlock_chk #(
   .NUM_DEV(NUM_DEV), .ADDR_W(ADDR_W), .PRI_INDEX(PRI_INDEX),
   .ALT_INDEX(ALT_INDEX), .ENTRY_KEY(ENTRY_KEY), .EXIT_KEY(EXIT_KEY)
) u_chk (
   .clk(clk), .rst_n(rst_n), .io_wr(io_wr), .io_rd(io_rd), .io_addr(io_addr),
   .io_wdata(io_wdata), .io_rdata(io_rdata), .alt_sel(alt_sel),
   .key_st(key_st), .dev_en(dev_en), .dev_base(dev_base)
);

// File: tb/sio_cfg_unlock_bench.sv
`timescale 1ns/1ps
module sio_cfg_unlock_bench;
   localparam int NDEV = 4;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              io_wr = 1'b0;
   logic              io_rd = 1'b0;
   logic              alt_sel = 1'b0;
   logic [15:0]       io_addr = '0;
   logic [7:0]        io_wdata = '0;
   logic [7:0]        io_rdata;
   logic [NDEV-1:0]   dev_en;
   logic [NDEV*16-1:0] dev_base;

   always #2.5 clk = ~clk;

   sio_cfg_unlock #(.NUM_DEV(NDEV)) u_sio_cfg_unlock (
      .clk(clk), .rst_n(rst_n), .io_wr(io_wr), .io_rd(io_rd),
      .io_addr(io_addr), .io_wdata(io_wdata), .io_rdata(io_rdata),
      .alt_sel(alt_sel), .dev_en(dev_en), .dev_base(dev_base)
   );

   int checks = 0;
   int errors = 0;
   bit done = 0;

   // behavioural reference: 0 locked, 1 one key seen, 2 unlocked
   int  m_st, m_ptr, m_sel;
   int  m_en[NDEV];
   int  m_base[NDEV];
   bit  m_live = 0;

   function automatic int pa();
      return alt_sel ? 'h2E : 'h4E;
   endfunction

   function automatic int exp_read(int a);
      if (m_st != 2) return 'hFF;
      if (a == pa()) return m_ptr;
      if (a != pa() + 1) return 'hFF;
      case (m_ptr)
         'h07: return m_sel;
         'h30: return (m_sel < NDEV) ? m_en[m_sel] : 0;
         'h60: return (m_sel < NDEV) ? (m_base[m_sel] >> 8) : 0;
         'h61: return (m_sel < NDEV) ? (m_base[m_sel] & 'hFF) : 0;
         default: return 0;
      endcase
   endfunction

   task automatic model_reset();
      m_st = 0; m_ptr = 0; m_sel = 0;
      for (int d = 0; d < NDEV; d++) begin m_en[d] = 0; m_base[d] = 0; end
   endtask

   task automatic model_step(bit w, bit r, int a, int v);
      bit isp = (a == pa());
      bit isv = (a == pa() + 1);
      if (w) begin
         if (isp) begin
            case (m_st)
               0: if (v == 'hA5) m_st = 1;
               1: m_st = (v == 'hA5) ? 2 : 0;
               default: if (v == 'hAA) m_st = 0; else m_ptr = v;
            endcase
         end else if (isv) begin
            if (m_st == 1) m_st = 0;
            else if (m_st == 2) begin
               if (m_ptr == 'h07) m_sel = v;
               else if (m_sel < NDEV) begin
                  if (m_ptr == 'h30) m_en[m_sel] = v & 1;
                  if (m_ptr == 'h60) m_base[m_sel] = (m_base[m_sel] & 'hFF) | (v << 8);
                  if (m_ptr == 'h61) m_base[m_sel] = (m_base[m_sel] & 'hFF00) | v;
               end
            end
         end
      end else if (r && isv && m_st == 1) m_st = 0;
   endtask

   task automatic check(string req, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual %0h expected %0h at %0t", req, act, exp, $time);
      end
   endtask

   task automatic wr(int a, int v);
      @(negedge clk);
      io_wr = 1'b1; io_addr = 16'(a); io_wdata = 8'(v);
      @(posedge clk); #1;
      model_step(1, 0, a, v);
      io_wr = 1'b0;
   endtask

   task automatic rd(int a, string req);
      @(negedge clk);
      io_rd = 1'b1; io_addr = 16'(a);
      #1 check(req, 32'(io_rdata), 32'(exp_read(a)));
      @(posedge clk); #1;
      model_step(0, 1, a, 0);
      io_rd = 1'b0;
   endtask

   task automatic do_reset();
      m_live = 0;
      rst_n = 1'b0;
      model_reset();
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      m_live = 1;
   endtask

   // per-clock comparison of the device outputs against the model (R8, R9)
   always @(negedge clk) begin
      if (m_live && !done) begin
         for (int d = 0; d < NDEV; d++) begin
            check("R8 enable", 32'(dev_en[d]), 32'(m_en[d]));
            check("R9 base", 32'(dev_base[d*16 +: 16]), 32'(m_base[d]));
         end
      end
   end

   initial begin
      #1_000_000;
      if (!done) begin
         done = 1;
         errors++;
         checks++;
         $display("FAIL watchdog expired");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      do_reset();
      // R1: reset state
      check("R1 en", 32'(dev_en), 0);
      check("R1 base", 32'(dev_base[31:0]), 0);
      rd('h4F, "R1");
      // R5: locked mode ignores value writes, reads give 0xFF
      wr('h4F, 'h55);
      rd('h4E, "R5");
      rd('h4F, "R5");
      // R2: one key is not enough (value read here also resets, R3)
      wr('h4E, 'hA5);
      rd('h4F, "R2");
      wr('h4E, 'hA5);
      wr('h4E, 'hA5);
      rd('h4E, "R2 unlocked");
      // R6 / R7
      wr('h4E, 'h07);
      rd('h4E, "R6");
      wr('h4F, 'h02);
      rd('h4F, "R7");
      // R8/R9: bring-up order on every device
      for (int d = 0; d < NDEV; d++) begin
         wr('h4E, 'h07); wr('h4F, d);
         wr('h4E, 'h30); wr('h4F, 0);
         wr('h4E, 'h60); wr('h4F, 'h10 + d);
         wr('h4E, 'h61); wr('h4F, 'hF8 - 8*d);
         wr('h4E, 'h30); wr('h4F, 'hFF - (d & 1));
         rd('h4F, "R8");
         wr('h4E, 'h60); rd('h4F, "R9");
         wr('h4E, 'h61); rd('h4F, "R9");
      end
      // R10: out-of-range device and unknown register
      wr('h4E, 'h07); wr('h4F, 'h09);
      wr('h4E, 'h30); wr('h4F, 'h00); rd('h4F, "R10");
      wr('h4E, 'h60); wr('h4F, 'h77); rd('h4F, "R10");
      wr('h4E, 'h61); wr('h4F, 'h77); rd('h4F, "R10");
      wr('h4E, 'h22); wr('h4F, 'h05); rd('h4F, "R10");
      // R4: exit key
      wr('h4E, 'hAA);
      rd('h4E, "R4");
      rd('h4F, "R4");
      wr('h4F, 'h00);
      // R3: interrupted sequences
      wr('h4E, 'hA5); wr('h4E, 'h3C); wr('h4E, 'hA5); rd('h4E, "R3 bad byte");
      wr('h4E, 'hAA);
      wr('h4E, 'hA5); wr('h4F, 'h00); wr('h4E, 'hA5); rd('h4E, "R3 value write");
      wr('h4E, 'hAA);
      wr('h4E, 'hA5); rd('h4E, "R3 pointer read"); wr('h4E, 'hA5);
      rd('h4E, "R3 still unlocks");
      wr('h4E, 'hAA);
      // R11: foreign address inside the key pair, wrong pair
      wr('h4E, 'hA5); wr('h80, 'h00); wr('h4E, 'hA5); rd('h4E, "R11 foreign");
      wr('h4E, 'hAA);
      wr('h2E, 'hA5); wr('h2E, 'hA5); rd('h4E, "R11 other pair");
      // R11: strapped to the alternate pair
      alt_sel = 1'b1;
      do_reset();
      wr('h4E, 'hA5); wr('h4E, 'hA5); rd('h2E, "R11 alt locked");
      wr('h2E, 'hA5); wr('h2E, 'hA5);
      wr('h2E, 'h07); wr('h2F, 'h01);
      wr('h2E, 'h61); wr('h2F, 'h3A);
      wr('h2E, 'h30); wr('h2F, 'h01);
      rd('h2F, "R11 alt data");
      wr('h4F, 'h00);
      rd('h2E, "R11 alt pointer");
      wr('h2E, 'hAA);
      rd('h2F, "R4 alt");
      @(negedge clk);
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule